// File: doc/BRIEF.md
# Half-Bridge Gate Drive Fault Supervisor

This block sits between a two-side PWM source and the gate prebuffers of a full-bridge power stage. In normal running each side passes its PWM input straight to its high-side gate and the inverted PWM to its low-side gate. Four fault sources can override this: an undervoltage flag, a thermal flag, an active-low external protect input, and an internal timer that spots a stalled PWM clock. When any fault is present the gates are forced at once, without waiting for a PWM edge, and an active-low fault line is pulled low.

An undervoltage forces both high-side gates low and both low-side gates high, so the bootstrap capacitors keep charging. Every other fault turns all four gates off. Once every fault has met its own clear condition, the block stays forced until the first rising edge on either PWM input. The cycle after that edge is sampled, both sides follow their PWM again and the fault line rises. After reset the block starts in the bootstrap-charging pattern and leaves it the same way. All inputs are taken as synchronous to `clk`. The analog comparators that produce the flags lie outside the block.

Top module: `gate_prot_ctrl`

## Requirements
- R1: While `uv_flag` is 1, in the same cycle, `hs_a` and `hs_b` are 0, `ls_a` and `ls_b` are 1, and `fault_n` is 0.
- R2: While `ot_flag` is 1 or `protect_n` is 0, and no undervoltage has been seen since the last recovery, all four gate outputs and `fault_n` are 0 in the same cycle.
- R3: When LOSS_CYCLES clock edges pass with no change on either PWM input, all four gates and `fault_n` go to 0. Any change on either PWM input restarts the count and clears this fault.
- R4: A low on `protect_n`, even for one cycle, keeps the outputs forced until recovery. Its clear condition is met only from the edge after the one that samples `protect_n` back at 1. A PWM rising edge sampled together with that protect rise does not recover.
- R5: When all faults have cleared, the outputs stay forced until a rising edge on `pwm_a` or `pwm_b` is sampled. After that edge the outputs run normally.
- R6: When undervoltage coincides with other faults, the undervoltage pattern wins. That pattern stays in force until recovery, even after the undervoltage itself clears.
- R7: During reset, and after it until the first recovery, the gates show the undervoltage pattern and `fault_n` is 0.
- R8: In normal running, `hs_a`=`pwm_a`, `ls_a`=!`pwm_a`, `hs_b`=`pwm_b`, `ls_b`=!`pwm_b` and `fault_n`=1.
- R9: PWM rising edges have no effect on the forced outputs while any fault is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| uv_flag | input | 1 | Supply undervoltage flag, 1 = fault |
| ot_flag | input | 1 | Over-temperature flag, 1 = fault |
| protect_n | input | 1 | External protect request, 0 = fault |
| pwm_a | input | 1 | PWM input, side A |
| pwm_b | input | 1 | PWM input, side B |
| hs_a | output | 1 | High-side gate drive, side A |
| ls_a | output | 1 | Low-side gate drive, side A |
| hs_b | output | 1 | High-side gate drive, side B |
| ls_b | output | 1 | Low-side gate drive, side B |
| fault_n | output | 1 | Fault indication, 0 = outputs forced |

## Verification
Two pairs of events can fall in the same cycle. The first is the release of the external protect input and a PWM rising edge. The bench raises `protect_n` and `pwm_b` in the same cycle and expects the outputs to stay forced, then expects recovery on the next rising edge. The second is undervoltage overlapping the thermal fault while a PWM rising edge arrives. There the bench expects the charging pattern to hold throughout, and to hold still after undervoltage alone has cleared.

// File: rtl/gate_prot_ctrl.sv
module gate_prot_ctrl #(
  parameter int LOSS_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_flag,
  input  logic ot_flag,
  input  logic protect_n,
  input  logic pwm_a,
  input  logic pwm_b,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic fault_n
);
  localparam int CW = $clog2(LOSS_CYCLES + 1);

  logic          pwm_a_q, pwm_b_q, prot_q;
  logic          ep_lat, lock, pre_mode;
  logic [CW-1:0] idle_cnt;

  logic activity, rise, cl_fault, faults_now, force_off, precharge;

  assign activity   = (pwm_a ^ pwm_a_q) | (pwm_b ^ pwm_b_q);
  assign rise       = (pwm_a & ~pwm_a_q) | (pwm_b & ~pwm_b_q);
  assign cl_fault   = (idle_cnt == CW'(LOSS_CYCLES));
  assign faults_now = uv_flag | ot_flag | ~protect_n | ep_lat | cl_fault;
  assign force_off  = lock | uv_flag | ot_flag | ~protect_n | cl_fault;
  assign precharge  = pre_mode | uv_flag;

  assign hs_a    = force_off ? 1'b0 : pwm_a;
  assign hs_b    = force_off ? 1'b0 : pwm_b;
  assign ls_a    = force_off ? precharge : ~pwm_a;
  assign ls_b    = force_off ? precharge : ~pwm_b;
  assign fault_n = ~force_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_a_q  <= 1'b0;
      pwm_b_q  <= 1'b0;
      prot_q   <= 1'b1;
      ep_lat   <= 1'b0;
      lock     <= 1'b1;
      pre_mode <= 1'b1;
      idle_cnt <= '0;
    end else begin
      pwm_a_q <= pwm_a;
      pwm_b_q <= pwm_b;
      prot_q  <= protect_n;

      if (!protect_n)          ep_lat <= 1'b1;
      else if (!prot_q)        ep_lat <= 1'b0;

      if (activity)            idle_cnt <= '0;
      else if (!cl_fault)      idle_cnt <= idle_cnt + 1'b1;

      if (uv_flag)             pre_mode <= 1'b1;
      else if (!faults_now && rise) pre_mode <= 1'b0;

      if (faults_now)          lock <= 1'b1;
      else if (rise)           lock <= 1'b0;
    end
  end

  p_uv_pattern_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> (!hs_a && !hs_b && ls_a && ls_b && !fault_n));

  p_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ot_flag || !protect_n) && !uv_flag && !pre_mode) |->
      (!hs_a && !hs_b && !ls_a && !ls_b && !fault_n));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= CW'(LOSS_CYCLES));

  p_protect_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !protect_n |=> !fault_n);

  p_hold_until_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !rise) |=> !fault_n);

  p_normal_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n |-> (hs_a == pwm_a && ls_a == !pwm_a && hs_b == pwm_b && ls_b == !pwm_b));
endmodule

// File: tb/gate_prot_ctrl_tb.sv
module gate_prot_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LOSS = 16;
  localparam int  NV = 17;
  // {req[3:0], uv, ot, protect_n, pwm_a, pwm_b, hs_a, ls_a, hs_b, ls_b, fault_n}
  localparam logic [13:0] VEC [NV] = '{
    {4'd7, 5'b00100, 5'b01010}, // R7 held after reset, no edge
    {4'd5, 5'b00110, 5'b10011}, // R5 first rise recovers
    {4'd8, 5'b00101, 5'b01101}, // R8 normal follow
    {4'd2, 5'b01101, 5'b00000}, // R2 over-temperature
    {4'd5, 5'b00100, 5'b00000}, // R5 cleared, no rise yet
    {4'd5, 5'b00110, 5'b10011}, // R5 rise recovers
    {4'd1, 5'b10110, 5'b01010}, // R1 undervoltage
    {4'd6, 5'b11101, 5'b01010}, // R6 uv+ot with rise
    {4'd6, 5'b01100, 5'b01010}, // R6 pattern kept after uv clears
    {4'd5, 5'b00110, 5'b10011}, // R5 recover
    {4'd2, 5'b00011, 5'b00000}, // R2 protect low
    {4'd4, 5'b00100, 5'b00000}, // R4 protect rise still forced
    {4'd4, 5'b00110, 5'b10011}, // R4 next rise recovers
    {4'd4, 5'b00000, 5'b00000}, // R4 protect low again
    {4'd4, 5'b00101, 5'b00000}, // R4 protect rise with pwm_b rise
    {4'd9, 5'b00100, 5'b00000}, // R9 still forced
    {4'd5, 5'b00101, 5'b01101}  // R5 rise b recovers
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic uv_flag = 1'b0, ot_flag = 1'b0, protect_n = 1'b1, pwm_a = 1'b0, pwm_b = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b, fault_n;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gate_prot_ctrl #(.LOSS_CYCLES(LOSS)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .protect_n(protect_n), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .fault_n(fault_n));

  task automatic check(input logic [4:0] exp, input int rq);
    logic [4:0] got;
    got = {hs_a, ls_a, hs_b, ls_b, fault_n};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d at %0t: got %b expected %b", rq, $time, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    check(5'b01010, 7); // R7 during reset
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {uv_flag, ot_flag, protect_n, pwm_a, pwm_b} = VEC[i][9:5];
      @(posedge clk); #1;
      check(VEC[i][4:0], int'(VEC[i][13:10]));
      @(negedge clk);
    end

    // R1: undervoltage forces outputs before any clock edge
    uv_flag = 1'b1; #1;
    check(5'b01010, 1);
    @(posedge clk); #1;
    check(5'b01010, 1);
    @(negedge clk) uv_flag = 1'b0; pwm_b = 1'b0;
    @(posedge clk); #1;
    check(5'b01010, 9); // R9 no rise, still forced
    @(negedge clk) pwm_a = 1'b1;
    @(posedge clk); #1;
    check(5'b10011, 5); // R5 recover on pwm_a rise

    // R3: clock loss after LOSS idle edges
    for (int k = 1; k < LOSS; k++) begin
      @(posedge clk); #1;
    end
    check(5'b10011, 3); // R3 one edge short of timeout
    @(posedge clk); #1;
    check(5'b00000, 3); // R3 timeout reached
    @(negedge clk) pwm_a = 1'b0;
    @(posedge clk); #1;
    check(5'b00000, 3); // R3 activity clears count, no rise yet
    @(negedge clk) pwm_a = 1'b1;
    @(posedge clk); #1;
    check(5'b10011, 3); // R3 rise recovers

    // R4: one-cycle protect pulse is held
    @(negedge clk) protect_n = 1'b0;
    @(negedge clk) protect_n = 1'b1; pwm_a = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(5'b00000, 4);
    end
    @(negedge clk) pwm_a = 1'b1;
    @(posedge clk); #1;
    check(5'b10011, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule